// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block is the issue stage of a multithreaded core that runs warps, groups of 32 threads that step through one instruction stream together. It keeps one buffered instruction for each resident warp. A fetch unit refills empty buffer slots through a fill port, at most one per cycle. The block tells that fetch unit which warp to serve next by rotating through the warps whose slot is empty.

A scoreboard marks, for each warp, the destination registers of instructions that are still in flight. A writeback port clears those marks. On each cycle where the execution unit can take work, the block picks at most one warp whose buffered instruction has no marked register. The warp that has waited longest wins, and ties are settled by rotating priority. The chosen instruction is sent to an execution unit with 8 lanes. That unit needs 4 cycles to run all 32 threads, so the block reports which group of 8 threads is being driven in each of those cycles.

Warps can be switched on and off one at a time. A warp that is switched off is neither fetched for nor issued.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, `issue_vld` and `unit_busy` are low, every buffer slot is empty, and `fetch_req` is high with `fetch_wid` = 0 when warp 0 is enabled.
- R2: A fill is accepted only when the target warp is enabled and its slot is empty. A fill to an occupied slot is ignored, and the buffered instruction is left unchanged.
- R3: `fetch_wid` names the first enabled warp with an empty slot, searching in increasing index order with wrap-around. The search starts just after the warp of the last accepted fill. `fetch_req` is low when no warp qualifies.
- R4: An instruction issues only when neither its two source registers nor its destination register are pending for its warp.
- R5: Issuing marks the destination register pending for that warp. A writeback clears the mark. When a writeback and an issue hit the same warp and register on the same edge, the register stays pending.
- R6: Two `issue_vld` pulses are at least 4 cycles apart, and each pulse lasts one cycle. `unit_busy` is high for exactly 4 cycles starting with the pulse. During those cycles `lane_grp` counts 0, 1, 2, 3 and the issue fields stay stable.
- R7: Among eligible warps, the one whose instruction has waited the most cycles is chosen (wait count saturates at 15). Ties go to the first warp in increasing index order after the last issued warp.
- R8: A disabled warp is never issued and never named by `fetch_req`. A fill to a disabled warp is ignored.
- R9: An instruction that is eligible and meets a free unit appears on `issue_vld` in the cycle after the edge that captured it. A writeback makes a blocked instruction issue one edge after the writeback edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_en | input | 24 | Per-warp enable |
| fetch_req | output | 1 | A warp with an empty slot is available |
| fetch_wid | output | 5 | Warp the fetch unit should serve next |
| fill_vld | input | 1 | Fill strobe |
| fill_wid | input | 5 | Warp being filled |
| fill_op | input | 8 | Opcode of the filled instruction |
| fill_dst | input | 4 | Destination register |
| fill_src_a | input | 4 | First source register |
| fill_src_b | input | 4 | Second source register |
| wb_vld | input | 1 | Writeback strobe |
| wb_wid | input | 5 | Warp of the writeback |
| wb_reg | input | 4 | Register written back |
| issue_vld | output | 1 | One-cycle pulse for a newly issued instruction |
| issue_wid | output | 5 | Warp of the issued instruction |
| issue_op | output | 8 | Issued opcode |
| issue_dst | output | 4 | Issued destination register |
| issue_src_a | output | 4 | Issued first source register |
| issue_src_b | output | 4 | Issued second source register |
| unit_busy | output | 1 | Execution unit occupied by the current dispatch |
| lane_grp | output | 2 | Group of 8 threads driven this cycle |

## Verification
Every result is registered, so each one is due a fixed number of edges after its stimulus:
- A fill is visible on `fetch_wid` right after its edge.
- The fill issues one edge later.
- A writeback releases its waiter one edge after the writeback edge.
- The following dispatch comes four edges after the previous one.

Inputs are driven at falling edges, and each result is sampled at the falling edge of the exact cycle it is due, never inside a polling loop. The bench also samples the cycles just before a result is due, to confirm that nothing appears early. Held-off cases are observed over a window well longer than the dispatch time.

// File: rtl/wis_pkg.sv
package wis_pkg;

   // Rotating index: (base + off) modulo n, for base and off below n.
   function automatic int unsigned rr_idx(input int unsigned base,
                                          input int unsigned off,
                                          input int unsigned n);
      int unsigned s;
      s = base + off;
      return (s >= n) ? s - n : s;
   endfunction

endpackage

// File: rtl/wis_ibuf.sv
module wis_ibuf #(
   parameter int NW    = 24,
   parameter int INS_W = 20,
   parameter int AGE_W = 4,
   localparam int WIDW = $clog2(NW)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NW-1:0]               warp_en,
   input  logic                        fill_vld,
   input  logic [WIDW-1:0]             fill_wid,
   input  logic [INS_W-1:0]            fill_ins,
   input  logic                        go,
   input  logic [WIDW-1:0]             go_wid,
   output logic [NW-1:0]               slot_vld,
   output logic [NW-1:0][INS_W-1:0]    slot_ins,
   output logic [NW-1:0][AGE_W-1:0]    slot_age,
   output logic                        fetch_req,
   output logic [WIDW-1:0]             fetch_wid
);
   import wis_pkg::*;

   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   logic            accept;
   logic [WIDW-1:0] fptr;

   assign accept = fill_vld && (int'(fill_wid) < NW) && warp_en[fill_wid]
                   && !slot_vld[fill_wid];

   // next warp to fetch for: first enabled empty slot from the pointer on
   always_comb begin
      int unsigned j;
      fetch_req = 1'b0;
      fetch_wid = '0;
      for (int i = 0; i < NW; i++) begin
         j = rr_idx(int'(fptr), i, NW);
         if (!fetch_req && warp_en[j] && !slot_vld[j]) begin
            fetch_req = 1'b1;
            fetch_wid = WIDW'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      fptr <= '0;
      else if (accept) fptr <= WIDW'(rr_idx(int'(fill_wid), 1, NW));
   end

   for (genvar w = 0; w < NW; w++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_vld[w] <= 1'b0;
            slot_ins[w] <= '0;
            slot_age[w] <= '0;
         end else if (accept && int'(fill_wid) == w) begin
            slot_vld[w] <= 1'b1;
            slot_ins[w] <= fill_ins;
            slot_age[w] <= '0;
         end else if (go && int'(go_wid) == w) begin
            slot_vld[w] <= 1'b0;
            slot_age[w] <= '0;
         end else if (slot_vld[w] && slot_age[w] != AGE_MAX) begin
            slot_age[w] <= slot_age[w] + 1'b1;
         end
      end

      // R2: a buffered instruction is only replaced after it leaves
      p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_vld[w] && !(go && int'(go_wid) == w)) |=> $stable(slot_ins[w]));
   end

   // R3/R8: fetch target is always an enabled, empty slot
   p_fetch_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> (warp_en[fetch_wid] && !slot_vld[fetch_wid]));

endmodule

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
   parameter int NW = 24,
   parameter int NR = 16,
   localparam int WIDW = $clog2(NW),
   localparam int RAW  = $clog2(NR)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_vld,
   input  logic [WIDW-1:0]          set_wid,
   input  logic [RAW-1:0]           set_reg,
   input  logic                     clr_vld,
   input  logic [WIDW-1:0]          clr_wid,
   input  logic [RAW-1:0]           clr_reg,
   output logic [NW-1:0][NR-1:0]    pend
);
   logic [NW-1:0][NR-1:0] set_m, clr_m;

   always_comb begin
      set_m = '0;
      clr_m = '0;
      if (set_vld) set_m[set_wid][set_reg] = 1'b1;
      if (clr_vld) clr_m[clr_wid][clr_reg] = 1'b1;
   end

   // set has priority over a same-edge clear
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_m) | set_m;
   end

   // R5: coincident set and clear leave the register pending
   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vld && clr_vld && set_wid == clr_wid && set_reg == clr_reg)
      |=> pend[$past(set_wid)][$past(set_reg)]);

   // R5: a lone clear releases the register
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld && !(set_vld && set_wid == clr_wid && set_reg == clr_reg))
      |=> !pend[$past(clr_wid)][$past(clr_reg)]);

endmodule

// File: rtl/wis_picker.sv
module wis_picker #(
   parameter int NW     = 24,
   parameter int AGE_W  = 4,
   parameter bit OLDEST = 1'b1,
   localparam int WIDW = $clog2(NW)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NW-1:0]             elig,
   input  logic [NW-1:0][AGE_W-1:0]  age,
   input  logic                      allow,
   output logic                      go,
   output logic [WIDW-1:0]           go_wid
);
   import wis_pkg::*;

   logic            found;
   logic [WIDW-1:0] ptr;

   if (OLDEST) begin : g_aged
      always_comb begin
         int unsigned j;
         logic [AGE_W-1:0] best;
         found  = 1'b0;
         go_wid = '0;
         best   = '0;
         for (int i = 0; i < NW; i++) begin
            j = rr_idx(int'(ptr), i, NW);
            if (elig[j] && (!found || age[j] > best)) begin
               found  = 1'b1;
               go_wid = WIDW'(j);
               best   = age[j];
            end
         end
      end
   end else begin : g_plain
      always_comb begin
         int unsigned j;
         found  = 1'b0;
         go_wid = '0;
         for (int i = 0; i < NW; i++) begin
            j = rr_idx(int'(ptr), i, NW);
            if (!found && elig[j]) begin
               found  = 1'b1;
               go_wid = WIDW'(j);
            end
         end
      end
   end

   assign go = found && allow;

   always_ff @(posedge clk) begin
      if (!rst_n)  ptr <= '0;
      else if (go) ptr <= WIDW'(rr_idx(int'(go_wid), 1, NW));
   end

   // R4/R8: only an eligible warp is granted
   p_grant_elig_r4: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> elig[go_wid]);

endmodule

// File: rtl/wis_dispatch.sv
module wis_dispatch #(
   parameter int DC    = 4,
   parameter int NW    = 24,
   parameter int INS_W = 20,
   localparam int WIDW = $clog2(NW),
   localparam int CW   = $clog2(DC + 1),
   localparam int LGW  = $clog2(DC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [WIDW-1:0]   go_wid,
   input  logic [INS_W-1:0]  go_ins,
   output logic              unit_free,
   output logic              issue_vld,
   output logic [WIDW-1:0]   issue_wid,
   output logic [INS_W-1:0]  issue_ins,
   output logic              unit_busy,
   output logic [LGW-1:0]    lane_grp
);
   logic [CW-1:0] cnt;

   // a new dispatch may start on the edge that ends the current one
   assign unit_free = (cnt <= CW'(1));
   assign unit_busy = (cnt != '0);
   assign lane_grp  = unit_busy ? LGW'(DC - int'(cnt)) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         issue_vld <= 1'b0;
         issue_wid <= '0;
         issue_ins <= '0;
      end else begin
         issue_vld <= go;
         if (go) begin
            cnt       <= CW'(DC);
            issue_wid <= go_wid;
            issue_ins <= go_ins;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // checker counter: cycles since the last pulse, saturating at DC
   logic [CW-1:0] since;
   always_ff @(posedge clk) begin
      if (!rst_n)         since <= CW'(DC);
      else if (issue_vld) since <= CW'(1);
      else if (since != CW'(DC)) since <= since + 1'b1;
   end

   p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_vld |-> (since == CW'(DC)));
   p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unit_busy) |-> issue_vld);
   p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_busy && !go) |=> $stable(issue_ins));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
   parameter int NUM_WARPS    = 24,
   parameter int NUM_REGS     = 16,
   parameter int OP_W         = 8,
   parameter int WARP_THREADS = 32,
   parameter int EXEC_LANES   = 8,
   parameter int AGE_W        = 4,
   parameter bit OLDEST_FIRST = 1'b1,
   localparam int WIDW  = $clog2(NUM_WARPS),
   localparam int RAW   = $clog2(NUM_REGS),
   localparam int DC    = WARP_THREADS / EXEC_LANES,
   localparam int LGW   = $clog2(DC),
   localparam int INS_W = OP_W + 3 * RAW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_WARPS-1:0]  warp_en,
   output logic                  fetch_req,
   output logic [WIDW-1:0]       fetch_wid,
   input  logic                  fill_vld,
   input  logic [WIDW-1:0]       fill_wid,
   input  logic [OP_W-1:0]       fill_op,
   input  logic [RAW-1:0]        fill_dst,
   input  logic [RAW-1:0]        fill_src_a,
   input  logic [RAW-1:0]        fill_src_b,
   input  logic                  wb_vld,
   input  logic [WIDW-1:0]       wb_wid,
   input  logic [RAW-1:0]        wb_reg,
   output logic                  issue_vld,
   output logic [WIDW-1:0]       issue_wid,
   output logic [OP_W-1:0]       issue_op,
   output logic [RAW-1:0]        issue_dst,
   output logic [RAW-1:0]        issue_src_a,
   output logic [RAW-1:0]        issue_src_b,
   output logic                  unit_busy,
   output logic [LGW-1:0]        lane_grp
);
   if (WARP_THREADS % EXEC_LANES != 0) begin : g_bad_lanes
      $error("WARP_THREADS must be a multiple of EXEC_LANES");
   end
   if (DC < 2) begin : g_bad_dc
      $error("dispatch must span at least two cycles");
   end
   if (NUM_WARPS < 2 || NUM_REGS < 2 || AGE_W < 1) begin : g_bad_size
      $error("NUM_WARPS, NUM_REGS and AGE_W out of range");
   end

   // instruction word layout: {op, dst, src_a, src_b}
   logic [NUM_WARPS-1:0]                  slot_vld;
   logic [NUM_WARPS-1:0][INS_W-1:0]       slot_ins;
   logic [NUM_WARPS-1:0][AGE_W-1:0]       slot_age;
   logic [NUM_WARPS-1:0][NUM_REGS-1:0]    pend;
   logic [NUM_WARPS-1:0]                  elig;
   logic                                  go, unit_free;
   logic [WIDW-1:0]                       go_wid;
   logic [INS_W-1:0]                      go_ins, issue_ins;

   wis_ibuf #(.NW(NUM_WARPS), .INS_W(INS_W), .AGE_W(AGE_W)) u_ibuf (
      .clk, .rst_n, .warp_en, .fill_vld, .fill_wid,
      .fill_ins ({fill_op, fill_dst, fill_src_a, fill_src_b}),
      .go, .go_wid, .slot_vld, .slot_ins, .slot_age, .fetch_req, .fetch_wid);

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
      logic [RAW-1:0] d, a, b;
      assign d = slot_ins[w][3*RAW-1:2*RAW];
      assign a = slot_ins[w][2*RAW-1:RAW];
      assign b = slot_ins[w][RAW-1:0];
      assign elig[w] = slot_vld[w] && warp_en[w]
                       && !pend[w][a] && !pend[w][b] && !pend[w][d];
   end

   assign go_ins = slot_ins[go_wid];

   wis_scoreboard #(.NW(NUM_WARPS), .NR(NUM_REGS)) u_sb (
      .clk, .rst_n,
      .set_vld (go), .set_wid (go_wid), .set_reg (go_ins[3*RAW-1:2*RAW]),
      .clr_vld (wb_vld), .clr_wid (wb_wid), .clr_reg (wb_reg),
      .pend);

   wis_picker #(.NW(NUM_WARPS), .AGE_W(AGE_W), .OLDEST(OLDEST_FIRST)) u_pick (
      .clk, .rst_n, .elig, .age (slot_age), .allow (unit_free), .go, .go_wid);

   wis_dispatch #(.DC(DC), .NW(NUM_WARPS), .INS_W(INS_W)) u_disp (
      .clk, .rst_n, .go, .go_wid, .go_ins, .unit_free,
      .issue_vld, .issue_wid, .issue_ins, .unit_busy, .lane_grp);

   assign issue_op    = issue_ins[INS_W-1:3*RAW];
   assign issue_dst   = issue_ins[3*RAW-1:2*RAW];
   assign issue_src_a = issue_ins[2*RAW-1:RAW];
   assign issue_src_b = issue_ins[RAW-1:0];

   // R4: a granted warp has every operand register free in the scoreboard
   p_src_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (!pend[go_wid][go_ins[2*RAW-1:RAW]] && !pend[go_wid][go_ins[RAW-1:0]]
              && !pend[go_wid][go_ins[3*RAW-1:2*RAW]]));
   // R8: a disabled warp is never granted
   p_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> warp_en[go_wid]);
   // R5: the issued destination is pending while it is announced
   p_dst_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      issue_vld |-> pend[issue_wid][issue_dst]);
   // R2: a grant always takes a filled slot
   p_slot_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> slot_vld[go_wid]);

endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] warp_en = '1;
   logic        fetch_req;
   logic [4:0]  fetch_wid;
   logic        fill_vld = 1'b0;
   logic [4:0]  fill_wid = '0;
   logic [7:0]  fill_op = '0;
   logic [3:0]  fill_dst = '0, fill_src_a = '0, fill_src_b = '0;
   logic        wb_vld = 1'b0;
   logic [4:0]  wb_wid = '0;
   logic [3:0]  wb_reg = '0;
   logic        issue_vld;
   logic [4:0]  issue_wid;
   logic [7:0]  issue_op;
   logic [3:0]  issue_dst, issue_src_a, issue_src_b;
   logic        unit_busy;
   logic [1:0]  lane_grp;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   warp_issue_sched uut (
      .clk, .rst_n, .warp_en, .fetch_req, .fetch_wid,
      .fill_vld, .fill_wid, .fill_op, .fill_dst, .fill_src_a, .fill_src_b,
      .wb_vld, .wb_wid, .wb_reg,
      .issue_vld, .issue_wid, .issue_op, .issue_dst, .issue_src_a, .issue_src_b,
      .unit_busy, .lane_grp);

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic fill(input int w, input int op, input int d, input int a, input int b);
      fill_vld = 1'b1; fill_wid = 5'(w); fill_op = 8'(op);
      fill_dst = 4'(d); fill_src_a = 4'(a); fill_src_b = 4'(b);
      tick();
      fill_vld = 1'b0;
   endtask

   task automatic wb(input int w, input int r);
      wb_vld = 1'b1; wb_wid = 5'(w); wb_reg = 4'(r);
      tick();
      wb_vld = 1'b0;
   endtask

   task automatic no_issue(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         tick();
         if (issue_vld) seen++;
      end
      chk(req, "issues during hold-off window", seen, 0);
   endtask

   task automatic exp_issue(input string req, input int w, input int op);
      chk(req, "issue_vld", int'(issue_vld), 1);
      chk(req, "issue_wid", int'(issue_wid), w);
      chk(req, "issue_op", int'(issue_op), op);
   endtask

   task automatic wait_idle();
      while (unit_busy) tick();
      tick();
   endtask

   // R1, R3, R8: reset state, fetch rotation, disabled warps
   task automatic t_reset_fetch();
      chk("R1", "issue_vld", int'(issue_vld), 0);
      chk("R1", "unit_busy", int'(unit_busy), 0);
      chk("R1", "fetch_req", int'(fetch_req), 1);
      chk("R1", "fetch_wid", int'(fetch_wid), 0);
      fill(0, 8'h01, 1, 2, 3);
      chk("R3", "fetch_wid after fill of warp 0", int'(fetch_wid), 1);
      tick();
      warp_en[1] = 1'b0; warp_en[2] = 1'b0;
      #1 chk("R3", "fetch_wid skips disabled warps", int'(fetch_wid), 3);
      warp_en = '0;
      #1 chk("R8", "fetch_req with all warps off", int'(fetch_req), 0);
      warp_en = '1;
      warp_en[9] = 1'b0;
      wait_idle();
      fill(9, 8'h09, 1, 2, 3);
      warp_en[9] = 1'b1;
      no_issue(6, "R8");
   endtask

   // R9, R6: exact issue cycle and dispatch occupancy
   task automatic t_dispatch();
      wait_idle();
      fill(3, 8'h11, 5, 1, 2);
      chk("R9", "issue_vld in fill cycle", int'(issue_vld), 0);
      tick();
      exp_issue("R9", 3, 8'h11);
      chk("R6", "lane_grp first", int'(lane_grp), 0);
      chk("R6", "unit_busy first", int'(unit_busy), 1);
      for (int g = 1; g < 4; g++) begin
         tick();
         chk("R6", "issue_vld pulse width", int'(issue_vld), 0);
         chk("R6", "unit_busy", int'(unit_busy), 1);
         chk("R6", "lane_grp", int'(lane_grp), g);
         chk("R6", "issue_dst held", int'(issue_dst), 5);
      end
      tick();
      chk("R6", "unit_busy after 4 cycles", int'(unit_busy), 0);
   endtask

   // R4, R2, R5, R9: source dependency and ignored refill
   task automatic t_raw();
      wait_idle();
      fill(3, 8'h22, 6, 5, 1);
      fill(3, 8'h99, 7, 0, 0);
      no_issue(6, "R4");
      wb(3, 5);
      chk("R9", "issue_vld on writeback edge", int'(issue_vld), 0);
      tick();
      exp_issue("R2", 3, 8'h22);
      chk("R4", "issue_src_a", int'(issue_src_a), 5);
   endtask

   // R4: destination still pending (write-after-write)
   task automatic t_waw();
      wait_idle();
      fill(8, 8'h33, 9, 1, 1);
      tick();
      exp_issue("R4", 8, 8'h33);
      wait_idle();
      fill(8, 8'h34, 9, 2, 3);
      no_issue(6, "R4");
      wb(8, 9);
      tick();
      exp_issue("R4", 8, 8'h34);
   endtask

   // R5: writeback on the same edge as the issue that sets the register
   task automatic t_same_edge();
      wait_idle();
      fill(6, 8'h44, 7, 0, 0);
      wb(6, 7);
      exp_issue("R5", 6, 8'h44);
      wait_idle();
      fill(6, 8'h45, 8, 7, 0);
      no_issue(6, "R5");
      wb(6, 7);
      tick();
      exp_issue("R5", 6, 8'h45);
   endtask

   // R7, R6: oldest wins over rotation; dispatches 4 cycles apart
   task automatic t_age();
      wait_idle();
      fill(1, 8'h51, 2, 0, 0);
      fill(10, 8'h5A, 4, 0, 0);
      exp_issue("R7", 1, 8'h51);
      fill(2, 8'h52, 4, 0, 0);
      tick();
      tick();
      chk("R6", "issue_vld before unit frees", int'(issue_vld), 0);
      tick();
      exp_issue("R7", 10, 8'h5A);
      tick(); tick(); tick();
      chk("R6", "issue_vld one cycle early", int'(issue_vld), 0);
      tick();
      exp_issue("R7", 2, 8'h52);
   endtask

   // R7, R8: saturated ages tie, rotation picks after last issued warp
   task automatic t_tie();
      wait_idle();
      fill(2, 8'h53, 6, 0, 0);
      fill(12, 8'h6C, 3, 0, 0);
      exp_issue("R7", 2, 8'h53);
      fill(1, 8'h61, 5, 0, 0);
      warp_en[12] = 1'b0; warp_en[1] = 1'b0;
      no_issue(20, "R8");
      warp_en[12] = 1'b1; warp_en[1] = 1'b1;
      tick();
      exp_issue("R7", 12, 8'h6C);
      tick(); tick(); tick(); tick();
      exp_issue("R7", 1, 8'h61);
   endtask

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset_fetch();
      t_dispatch();
      t_raw();
      t_waw();
      t_same_edge();
      t_age();
      t_tie();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule